// File: doc/BRIEF.md
# Watchdog Timer with Protected Disable

This block is a watchdog timer. It counts pulses of a slow clock-enable input that comes from a separate watchdog oscillator. When the count reaches a selectable limit, the block sends a one-cycle reset pulse to the system. Software must restart the count in time by pulsing the kick input. A small 8-bit control register holds three things: the enable flag, a disarm-permission flag and a 3-bit period select. The select chooses a time-out of 2^(BASE_LOG2 + select) oscillator ticks, where BASE_LOG2 is 14 by default.

A single stray write cannot stop a running watchdog. Software first writes ones to the disarm-permission and enable bits in the same write. The permission flag then stays set for UNLOCK_CYCLES system clock cycles (four by default) and clears by itself. A write of zero to the enable bit takes effect only while the permission flag is set.

Top module: `wdt_top`

## Requirements
- R1: After reset every register bit reads as 0. Read bits 7..5 are always 0, whatever value is written to them.
- R2: A write loads the period select from data bits 2..0. A write with data bit 3 set sets the enable flag. The read port returns {3'b000, permission (bit 4), enable (bit 3), select (bits 2..0)} in the cycle after the write.
- R3: A write with data bit 3 clear leaves the enable flag set unless the permission flag is already 1 before that write.
- R4: A write with both data bit 4 and data bit 3 set sets the permission flag. The flag then reads 1 for exactly 4 clock cycles after that write and returns to 0 on its own.
- R5: A write of 0 to the enable bit on any of the 4 clock edges that follow the unlocking write clears the enable flag. The same write on the 5th edge leaves the enable flag set.
- R6: While the block is enabled, the time-out fires on the 2^(BASE_LOG2+select)-th tick counted from zero. The reset output is then high for exactly one clock cycle, and the count restarts at zero.
- R7: A kick clears the count to zero. If a kick arrives in the same cycle as the tick that would have caused a time-out, the kick wins and no reset pulse is sent.
- R8: While the block is disabled, ticks do not advance the count and the reset output stays 0.
- R9: Changing the select does not clear the count. If the new limit is at or below the current count, the time-out fires on the next tick.
- R10: Data bit 4 written with data bit 3 clear does not set the permission flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read value |
| kick | input | 1 | Restart the count from zero |
| wdtTick | input | 1 | Watchdog oscillator tick, one system cycle wide |
| wdtResetOut | output | 1 | One-cycle system reset request on time-out |

## Verification
A faulty permission window shows up on the read port in the cycle after the fault. Either bit 4 clears one cycle early or late, or a disable write on the 4th or 5th edge gives the wrong enable value. A fault in the counter or the limit stays hidden until the next time-out is due. It then appears as a reset pulse one or more ticks early or late, or as a pulse missing after a kick or a select change. The bench therefore compares every cycle against a reference model and reaches time-outs at several select values.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int SEL_W = 3;

  // Strobes passed from the control register to the counting datapath
  typedef struct packed {
    logic             run;    // count enabled
    logic             clear;  // restart count from zero
    logic [SEL_W-1:0] sel;    // period select
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int UNLOCK_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              kick,
  output logic [DATA_W-1:0] rdData,
  output wdtStrobe_t        strobe
);
  localparam int EN_BIT  = SEL_W;
  localparam int TOE_BIT = SEL_W + 1;
  localparam int WIN_W   = $clog2(UNLOCK_CYCLES + 1);
  localparam int RSV_W   = DATA_W - SEL_W - 2;

  logic             enFlag;
  logic             permFlag;
  logic [SEL_W-1:0] selReg;
  logic [WIN_W-1:0] winCnt;
  logic             unlockWr;
  logic             unusedRsvd;

  assign unlockWr   = wrEn & wrData[TOE_BIT] & wrData[EN_BIT];
  assign unusedRsvd = ^wrData[DATA_W-1:TOE_BIT+1];

  // Select and enable flag; clearing enable needs the permission flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= '0;
      enFlag <= 1'b0;
    end else if (wrEn) begin
      selReg <= wrData[SEL_W-1:0];
      if (wrData[EN_BIT])  enFlag <= 1'b1;
      else if (permFlag)   enFlag <= 1'b0;
    end
  end

  // Permission window: held for UNLOCK_CYCLES cycles after the unlocking write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      permFlag <= 1'b0;
      winCnt   <= '0;
    end else if (unlockWr) begin
      permFlag <= 1'b1;
      winCnt   <= WIN_W'(UNLOCK_CYCLES - 1);
    end else if (permFlag) begin
      if (winCnt == '0) permFlag <= 1'b0;
      else              winCnt   <= winCnt - 1'b1;
    end
  end

  assign rdData       = {{RSV_W{1'b0}}, permFlag, enFlag, selReg};
  assign strobe.run   = enFlag;
  assign strobe.clear = kick;
  assign strobe.sel   = selReg;
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 14
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  wdtStrobe_t strobe,
  output logic       timeout
);
  localparam int CNT_W = BASE_LOG2 + (2 ** SEL_W);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntNext;
  logic [CNT_W-1:0] limit;
  logic             hit;

  assign limit   = {{(CNT_W-1){1'b0}}, 1'b1} << (BASE_LOG2 + int'(strobe.sel));
  assign cntNext = cnt + 1'b1;
  assign hit     = cntNext >= limit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      timeout <= 1'b0;
    end else begin
      timeout <= 1'b0;
      if (strobe.clear) begin
        cnt <= '0;
      end else if (strobe.run && tick) begin
        if (hit) begin
          cnt     <= '0;
          timeout <= 1'b1;
        end else begin
          cnt <= cntNext;
        end
      end
    end
  end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2     = 14,
  parameter int UNLOCK_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       kick,
  input  logic       wdtTick,
  output logic       wdtResetOut
);
  wdtStrobe_t strobe;

  wdt_ctrl #(.DATA_W(8), .UNLOCK_CYCLES(UNLOCK_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .kick(kick),
    .rdData(rdData), .strobe(strobe)
  );

  wdt_datapath #(.BASE_LOG2(BASE_LOG2)) i_dp (
    .clk(clk), .rstN(rstN), .tick(wdtTick), .strobe(strobe),
    .timeout(wdtResetOut)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       kick,
  input logic [7:0] rdData,
  input logic       wdtResetOut
);
  p_rsv_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    rdData[7:5] == 3'b000);

  p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(rdData[2:0]));

  p_en_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[3] && !rdData[4]) |=> rdData[3]);

  p_perm_needs_en_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdData[4]) |-> rdData[3]);

  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    wdtResetOut |=> !wdtResetOut);

  p_kick_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    kick |=> !wdtResetOut);

  p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[3] |=> !wdtResetOut);
endmodule

bind wdt_top wdt_checker i_wdtChecker (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .kick(kick),
  .rdData(rdData), .wdtResetOut(wdtResetOut)
);

// File: tb/test_wdt_top.sv
module test_wdt_top;
  localparam int BASE = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       kick = 1'b0;
  logic       wdtTick = 1'b0;
  logic       wdtResetOut;

  int nChk = 0;
  int nFail = 0;

  // reference model state
  logic       mEn = 0, mPerm = 0, mRst = 0;
  logic [2:0] mSel = 0;
  int         mWin = 0;
  int         mCnt = 0;

  always #2.5 clk = ~clk;

  wdt_top #(.BASE_LOG2(BASE), .UNLOCK_CYCLES(4)) i_wdt_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .kick(kick), .wdtTick(wdtTick), .wdtResetOut(wdtResetOut)
  );

  function automatic int limitOf(input logic [2:0] s);
    return 1 << (BASE + int'(s));
  endfunction

  function automatic logic [7:0] expRd();
    return {3'b000, mPerm, mEn, mSel};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelStep(input logic w, input logic [7:0] d, input logic k, input logic t);
    logic nextRst;
    logic oldPerm;
    nextRst = 1'b0;
    oldPerm = mPerm;
    if (k) mCnt = 0;
    else if (mEn && t) begin
      if (mCnt + 1 >= limitOf(mSel)) begin mCnt = 0; nextRst = 1'b1; end
      else mCnt = mCnt + 1;
    end
    if (w) begin
      mSel = d[2:0];
      if (d[3]) mEn = 1'b1;
      else if (oldPerm) mEn = 1'b0;
    end
    if (w && d[4] && d[3]) begin mPerm = 1'b1; mWin = 3; end
    else if (mPerm) begin
      if (mWin == 0) mPerm = 1'b0;
      else mWin = mWin - 1;
    end
    mRst = nextRst;
  endtask

  // One clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input logic w, input logic [7:0] d, input logic k, input logic t);
    wrEn = w; wrData = d; kick = k; wdtTick = t;
    @(posedge clk);
    modelStep(w, d, k, t);
    @(negedge clk);
    wrEn = 1'b0; kick = 1'b0; wdtTick = 1'b0;
    chk("R2 model register", int'(rdData), int'(expRd()));
    chk("R6 model reset pulse", int'(wdtResetOut), int'(mRst));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  %0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    int seenRst;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset read", int'(rdData), 0);
    chk("R1 reset output", int'(wdtResetOut), 0);

    cyc(1'b1, 8'h0B, 1'b0, 1'b0);
    chk("R2 enable+select", int'(rdData), 'h0B);
    cyc(1'b1, 8'hEB, 1'b0, 1'b0);
    chk("R1 reserved read zero", int'(rdData), 'h0B);
    cyc(1'b1, 8'h00, 1'b0, 1'b0);
    chk("R3 enable sticky", int'(rdData), 'h08);

    cyc(1'b1, 8'h1B, 1'b0, 1'b0);
    chk("R4 permission set", int'(rdData), 'h1B);
    for (int i = 0; i < 3; i++) begin
      idle(1);
      chk("R4 permission held", int'(rdData[4]), 1);
    end
    idle(1);
    chk("R4 permission auto clear", int'(rdData), 'h0B);

    cyc(1'b1, 8'h18, 1'b0, 1'b0);
    idle(3);
    cyc(1'b1, 8'h00, 1'b0, 1'b0);
    chk("R5 disable on 4th edge", int'(rdData[3]), 0);

    cyc(1'b1, 8'h08, 1'b0, 1'b0);
    cyc(1'b1, 8'h18, 1'b0, 1'b0);
    idle(4);
    cyc(1'b1, 8'h00, 1'b0, 1'b0);
    chk("R5 disable late on 5th edge", int'(rdData), 'h08);

    cyc(1'b1, 8'h13, 1'b0, 1'b0);
    chk("R10 bit4 without bit3", int'(rdData[4]), 0);
    chk("R10 enable kept", int'(rdData), 'h0B);

    // R6: select 0 -> limit 8 ticks
    cyc(1'b1, 8'h08, 1'b1, 1'b0);
    ticks(7);
    chk("R6 no early reset", int'(wdtResetOut), 0);
    ticks(1);
    chk("R6 reset on limit", int'(wdtResetOut), 1);
    idle(1);
    chk("R6 single pulse", int'(wdtResetOut), 0);

    // R7: kick restarts, kick beats coincident tick
    ticks(5);
    cyc(1'b0, 8'h00, 1'b1, 1'b0);
    ticks(7);
    chk("R7 no reset after kick", int'(wdtResetOut), 0);
    cyc(1'b0, 8'h00, 1'b1, 1'b1);
    chk("R7 kick beats tick", int'(wdtResetOut), 0);
    ticks(7);
    chk("R7 restarted count", int'(wdtResetOut), 0);
    ticks(1);
    chk("R7 fires after full period", int'(wdtResetOut), 1);

    // R9: limit 32, count 20, drop to limit 8
    cyc(1'b1, 8'h0A, 1'b1, 1'b0);
    ticks(20);
    cyc(1'b1, 8'h08, 1'b0, 1'b0);
    chk("R9 no reset on select change", int'(wdtResetOut), 0);
    ticks(1);
    chk("R9 reset on next tick", int'(wdtResetOut), 1);

    // R8: disabled holds
    cyc(1'b1, 8'h18, 1'b0, 1'b0);
    cyc(1'b1, 8'h00, 1'b0, 1'b0);
    chk("R8 disabled", int'(rdData[3]), 0);
    seenRst = 0;
    for (int i = 0; i < 100; i++) begin
      ticks(1);
      if (wdtResetOut) seenRst++;
    end
    chk("R8 no reset while disabled", seenRst, 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic w;
      logic [7:0] d;
      w = ($urandom % 12) == 0;
      d = 8'($urandom);
      if (($urandom % 3) == 0) d[4:3] = 2'b11;
      if (($urandom % 2) == 0) d[2] = 1'b0;
      cyc(w, d, ($urandom % 200) == 0, ($urandom % 3) != 0);
    end

    $display("  %0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule